// File: doc/BRIEF.md
# Matrix Square Compute Engine

The engine squares one square matrix of signed 16-bit integers held in row-major order, producing out = A×A. After a start request it accepts the LEN×LEN input words on a valid/ready stream and keeps them in an on-chip store. It then emits the LEN×LEN results on a second valid/ready stream, in row-major order.

For every result the engine walks the store with two running addresses. The row address steps by one and the column address steps by LEN. Along the way it copies one row and one column into two operand register banks. It then forms the LEN products in parallel and sums them in a single cycle. Row, column and row base come from counters and adders only; no multiply, divide or modulus takes part in addressing. A one-cycle done pulse marks the end of a run.

Top module: `msq_engine`

## Requirements
- R1: While reset is applied, and after it is released, in_ready, out_valid and done are all low until start is seen.
- R2: A start pulse while idle opens the load phase. in_ready is high and exactly LEN*LEN words are accepted. Input word n is element (n/LEN, n mod LEN). After the last word, in_ready drops.
- R3: Each result equals the sum over k of A(r,k)*A(k,c) as a signed value. The accumulator starts at zero and exactly LEN products contribute.
- R4: Results leave in row-major order, starting at row 0 column 0. Exactly LEN*LEN results are produced per start, and no element is skipped or repeated.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R6: done is high for exactly one cycle, the cycle after the last result is accepted.
- R7: A start pulse during the load or compute phases has no effect on the data taken or produced. No new run begins after done unless start arrives again.
- R8: out_data is 2*16+ceil(log2(LEN+1)) bits wide and signed. Inputs of all -32768 give LEN*2^30 in every result, with no overflow.
- R9: in_valid and in_data are ignored outside the load phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run when idle |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Engine accepts an input word |
| in_data | input | DW | Signed matrix element |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer accepts a result |
| out_data | output | OW | Signed result element |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Suppose a row-base or column counter steps at the wrong moment. The fault shows in the very first result whose row or column is affected. That is LEN+2 cycles after the prior handshake. Only a small, fixed set of elements is shared with the correct result, so the value comes out wrong. A missing step in the row or column address sends the wrong element into an operand bank, and the next result is off. A phase-control fault is different: it shows as a wrong handshake level, a result count other than LEN*LEN, or a done pulse that is missing, early or doubled. The reference compares every cycle in which out_valid is high, so a fault is reported in the cycle it first reaches the port.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_GATHER,
    PH_REDUCE,
    PH_EMIT
  } msq_phase_e;
endpackage

// File: rtl/msq_store.sv
module msq_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_addr_a,
  input  logic [IW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/msq_walker.sv
module msq_walker #(
  parameter int LEN   = 4,
  localparam int DEPTH = LEN * LEN,
  localparam int IW    = $clog2(DEPTH),
  localparam int SW    = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clear,
  input  logic          step_en,
  input  logic          next_out,
  output logic [IW-1:0] row_addr,
  output logic [IW-1:0] col_addr,
  output logic [SW-1:0] step,
  output logic          last_step,
  output logic          last_out
);
  localparam logic [IW-1:0] LAST_BASE = IW'(DEPTH - LEN);
  localparam logic [IW-1:0] STRIDE    = IW'(LEN);

  logic [IW-1:0] base_q, base_d, ra_q, ra_d, ca_q, ca_d;
  logic [SW-1:0] col_q, col_d, step_q, step_d;
  logic          col_wrap;

  assign col_wrap = (col_q == SW'(LEN - 1));

  always_comb begin
    base_d = base_q;
    col_d  = col_q;
    ra_d   = ra_q;
    ca_d   = ca_q;
    step_d = step_q;
    if (clear) begin
      base_d = '0;
      col_d  = '0;
      ra_d   = '0;
      ca_d   = '0;
      step_d = '0;
    end else if (next_out) begin
      if (col_wrap) begin
        col_d  = '0;
        base_d = base_q + STRIDE;
      end else begin
        col_d  = col_q + SW'(1);
      end
      ra_d   = base_d;
      ca_d   = IW'(col_d);
      step_d = '0;
    end else if (step_en) begin
      ra_d   = ra_q + IW'(1);
      ca_d   = ca_q + STRIDE;
      step_d = step_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      col_q  <= '0;
      ra_q   <= '0;
      ca_q   <= '0;
      step_q <= '0;
    end else if (clear || next_out || step_en) begin
      base_q <= base_d;
      col_q  <= col_d;
      ra_q   <= ra_d;
      ca_q   <= ca_d;
      step_q <= step_d;
    end
  end

  assign row_addr  = ra_q;
  assign col_addr  = ca_q;
  assign step      = step_q;
  assign last_step = (step_q == SW'(LEN - 1));
  assign last_out  = col_wrap && (base_q == LAST_BASE);

  a_r4_col_range: assert property (@(posedge clk) disable iff (!rst_ni)
    col_q <= SW'(LEN - 1));
  a_r4_base_advance: assert property (@(posedge clk) disable iff (!rst_ni)
    (next_out && !clear && col_wrap) |=> (base_q == $past(base_q) + STRIDE) && (col_q == '0));
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    step_en |-> step_q < SW'(LEN - 1));
endmodule

// File: rtl/msq_reduce.sv
module msq_reduce #(
  parameter int LEN = 4,
  parameter int DW  = 16,
  parameter int OW  = 2 * DW + $clog2(LEN + 1)
) (
  input  logic signed [DW-1:0] row_op [LEN],
  input  logic signed [DW-1:0] col_op [LEN],
  output logic signed [OW-1:0] sum
);
  logic signed [2*DW-1:0] prod [LEN];

  for (genvar g = 0; g < LEN; g++) begin : g_mul
    assign prod[g] = row_op[g] * col_op[g];
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < LEN; k++) begin
      sum = sum + OW'(prod[k]);
    end
  end
endmodule

// File: rtl/msq_engine.sv
module msq_engine
  import msq_pkg::*;
#(
  parameter int LEN = 4,
  parameter int DW  = 16,
  parameter int OW  = 2 * DW + $clog2(LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data,
  output logic          done
);
  localparam int DEPTH = LEN * LEN;
  localparam int IW    = $clog2(DEPTH);
  localparam int SW    = $clog2(LEN);

  logic rst_s1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ni   <= rst_s1_q;
    end
  end

  msq_phase_e state_q, state_d;
  logic [IW-1:0] ld_cnt_q;
  logic          done_q, done_d;
  logic signed [OW-1:0] res_q, sum_w;
  logic signed [DW-1:0] rbuf_q [LEN];
  logic signed [DW-1:0] cbuf_q [LEN];

  logic          clear_w, step_en, next_out, ld_en, gat_en, res_en;
  logic [IW-1:0] row_addr, col_addr;
  logic [SW-1:0] step;
  logic          last_step, last_out;
  logic [DW-1:0] rd_a, rd_b;

  msq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .wr_en     (ld_en),
    .wr_addr   (ld_cnt_q),
    .wr_data   (in_data),
    .rd_addr_a (row_addr),
    .rd_addr_b (col_addr),
    .rd_data_a (rd_a),
    .rd_data_b (rd_b)
  );

  msq_walker #(.LEN(LEN)) u_walk (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .clear     (clear_w),
    .step_en   (step_en),
    .next_out  (next_out),
    .row_addr  (row_addr),
    .col_addr  (col_addr),
    .step      (step),
    .last_step (last_step),
    .last_out  (last_out)
  );

  msq_reduce #(.LEN(LEN), .DW(DW), .OW(OW)) u_reduce (
    .row_op (rbuf_q),
    .col_op (cbuf_q),
    .sum    (sum_w)
  );

  always_comb begin
    state_d  = state_q;
    clear_w  = 1'b0;
    step_en  = 1'b0;
    next_out = 1'b0;
    ld_en    = 1'b0;
    gat_en   = 1'b0;
    res_en   = 1'b0;
    done_d   = 1'b0;
    case (state_q)
      PH_IDLE: if (start) begin
        state_d = PH_LOAD;
        clear_w = 1'b1;
      end
      PH_LOAD: if (in_valid) begin
        ld_en = 1'b1;
        if (ld_cnt_q == IW'(DEPTH - 1)) state_d = PH_GATHER;
      end
      PH_GATHER: begin
        gat_en = 1'b1;
        if (last_step) state_d = PH_REDUCE;
        else           step_en = 1'b1;
      end
      PH_REDUCE: begin
        res_en  = 1'b1;
        state_d = PH_EMIT;
      end
      PH_EMIT: if (out_ready) begin
        if (last_out) begin
          done_d  = 1'b1;
          state_d = PH_IDLE;
        end else begin
          next_out = 1'b1;
          state_d  = PH_GATHER;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_IDLE;
      ld_cnt_q <= '0;
      done_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (clear_w)    ld_cnt_q <= '0;
      else if (ld_en) ld_cnt_q <= ld_cnt_q + IW'(1);
      if (res_en)     res_q <= sum_w;
    end
  end

  always_ff @(posedge clk) begin
    if (gat_en) begin
      rbuf_q[step] <= $signed(rd_a);
      cbuf_q[step] <= $signed(rd_b);
    end
  end

  assign in_ready  = (state_q == PH_LOAD);
  assign out_valid = (state_q == PH_EMIT);
  assign out_data  = res_q;
  assign done      = done_q;

  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done) |-> !out_valid && !in_ready);
  a_r2_stream_exclusive: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones({in_ready, out_valid, done}) <= 1);
endmodule

// File: tb/msq_engine_bench.sv
`timescale 1ns/1ps
module msq_engine_bench;
  localparam int L   = 3;
  localparam int DW  = 16;
  localparam int D   = L * L;
  localparam int BOW = 2 * DW + $clog2(L + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, done;
  logic [BOW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  longint am [D];

  always #2.5 clk = ~clk;

  msq_engine #(.LEN(L), .DW(DW)) u_msq_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint elem(input int pat, input int n);
    case (pat)
      0: return longint'(n + 1);
      1: return longint'((n * 37) % 201) - 100;
      2: return -32768;
      default: return (n % 2 == 0) ? 32767 : -32768;
    endcase
  endfunction

  function automatic longint ref_val(input int idx);
    longint s = 0;
    int r = idx / L;
    int c = idx % L;
    for (int k = 0; k < L; k++) s += am[r*L + k] * am[k*L + c];
    return s;
  endfunction

  // R2 R7: load with optional gaps and a stray start
  task automatic load_matrix(input int pat, input bit gaps);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b1, "R2 in_ready after start", in_ready, 1);
    for (int n = 0; n < D; n++) begin
      bit acc;
      am[n] = elem(pat, n);
      if (gaps && (n % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      acc = 1'b0;
      while (!acc) begin
        in_valid = 1'b1;
        in_data  = DW'(am[n]);
        start    = (n == 2);
        acc      = in_ready;
        if (!acc) @(negedge clk);
      end
      @(negedge clk);
      start = 1'b0;
    end
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 in_ready low after last word", in_ready, 0);
  endtask

  // R3 R4 R5 R6 R8 R9: drain and compare every valid cycle
  task automatic drain(input int rmode);
    int idx = 0;
    bit hold = 1'b0;
    logic [BOW-1:0] prev = '0;
    int k = 0;
    while (idx < D) begin
      out_ready = (rmode == 0) ? 1'b1 : ((k % 3) != 0);
      in_valid  = 1'b1;
      in_data   = 16'h7abc;
      start     = (k == 5);
      if (out_valid) begin
        if (hold) chk(out_data == prev, "R5 data held", $signed(out_data), $signed(prev));
        chk($signed(out_data) == ref_val(idx), "R3 R4 R8 result", $signed(out_data), ref_val(idx));
        chk(done == 1'b0, "R6 no early done", done, 0);
        if (out_ready) idx++;
      end else begin
        chk(!hold, "R5 valid held", out_valid, 1);
      end
      hold = out_valid && !out_ready;
      prev = out_data;
      k++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    in_valid  = 1'b0;
    start     = 1'b0;
    chk(done == 1'b1, "R6 done after last accept", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    for (int t = 0; t < 3; t++) begin
      chk(in_ready == 1'b0 && out_valid == 1'b0, "R7 no new run", {in_ready, out_valid}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_cmp++;
    n_bad++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R1 during reset",
        {in_ready, out_valid, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R1 after reset",
        {in_ready, out_valid, done}, 0);
    in_valid = 1'b1;
    in_data  = 16'h1234;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R9 idle ignores input", in_ready, 0);

    load_matrix(0, 1'b0);
    drain(0);
    load_matrix(1, 1'b1);
    drain(1);
    load_matrix(2, 1'b0);
    drain(1);
    load_matrix(3, 1'b1);
    drain(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule